// File: doc/BRIEF.md
# Integer Normalizer with Leading and Trailing Zero Counts

This block takes a 32-bit word and shifts it left until its most significant information bit lands at a fixed position. It reports the shift it applied. It also reports how many zero bits lie below the lowest set bit. A mode input chooses between two interpretations of the word.

- In unsigned mode the highest set bit is moved to bit 31.
- In signed (two's complement) mode the redundant copies of the sign are removed, so that one sign bit stays at bit 31 and the first bit that differs from it sits at bit 30.

The signed case does not have its own search. It is mapped onto the unsigned search by combining the word with a copy of itself moved up one place. In the combined word, a set bit marks each place where two neighbouring bits of the operand differ. The leading-zero search works in five steps of halving width. The trailing count isolates the lowest set bit with a two's complement mask and then encodes its position.

All results are registered once. The block accepts one operand on every clock and returns its result exactly one cycle later. It suits normalization ahead of iterative division, fixed-point scaling and priority selection.

Top module: `bit_normalizer`

## Requirements
- R1: `out_valid` is high in the cycle after each clock edge where `in_valid` was sampled high, and low after each edge where it was sampled low (latency of one clock).
- R2: While `rst_n` is low, and after the first edge with it low, `out_valid` is 0 and `out_data`, `out_lead` and `out_trail` are all 0.
- R3: In unsigned mode (`in_signed` = 0) with a nonzero operand, `out_lead` equals the number of zero bits above the highest set bit. `out_data` equals the operand shifted left by `out_lead`, so bit 31 of `out_data` is 1.
- R4: In unsigned mode a zero operand gives `out_lead` = 32 and `out_data` = 0.
- R5: In signed mode (`in_signed` = 1), `out_lead` equals the number of bits directly below bit 31 that match bit 31, counted down to the first bit that differs. `out_data` equals the operand shifted left by `out_lead`. For any operand other than 0 and 0xFFFFFFFF, bits 31 and 30 of `out_data` differ.
- R6: In signed mode, operands 0 and 0xFFFFFFFF both give `out_lead` = 31. The resulting `out_data` is 0x00000000 and 0x80000000 respectively.
- R7: For a nonzero operand, `out_trail` equals the index of the lowest set bit (0 to 31).
- R8: A zero operand gives `out_trail` = 32.
- R9: `out_trail` does not depend on `in_signed`.
- R10: When `in_valid` is low at an edge, `out_data`, `out_lead` and `out_trail` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand strobe |
| in_data | input | 32 | Operand |
| in_signed | input | 1 | 1 = two's complement normalization, 0 = unsigned |
| out_valid | output | 1 | Result strobe, one clock after `in_valid` |
| out_data | output | 32 | Normalized operand |
| out_lead | output | 6 | Left shift applied (0 to 32) |
| out_trail | output | 6 | Zeros below the lowest set bit (0 to 32) |

## Verification
The properties take two things for granted about the inputs.
- `in_data` and `in_signed` are steady whenever `in_valid` is sampled high, and no unknown value reaches them. Each property relates the registered result to the operand and mode seen one edge earlier through `$past`.
- The two all-sign-bit words are the only signed operands exempt from the bit 31 / bit 30 check.

The directed tasks keep to these assumptions. They change inputs only on the falling edge and deassert `in_valid` between operands. The signed tasks also drive the two exempt words on purpose, so that the special shift of 31 is seen.

// File: rtl/norm_pkg.sv
// Package norm_pkg
// Shared mode type and width helpers for the normalizer.
// Assumes the data width is a power of two of at least 4.
package norm_pkg;

    // Interpretation applied to the operand
    typedef enum logic {
        NORM_UNSIGNED = 1'b0,
        NORM_SIGNED   = 1'b1
    } norm_mode_e;

    // Number of halving steps needed to search a word of width w
    function automatic int unsigned steps_for(input int unsigned w);
        int unsigned n;
        n = 0;
        while ((1 << n) < w) n++;
        return n;
    endfunction

endpackage

// File: rtl/norm_fold.sv
// Module norm_fold
// Maps the operand onto the word that the leading-zero search should scan.
// Unsigned mode passes the operand through.
// Signed mode sets a bit wherever two neighbouring operand bits differ,
// so the leading one marks the first non-sign bit. Bit 0 is forced to 1,
// so the all-sign words (0 and all ones) report a shift of W-1.
// Assumes: purely combinational, no state.
module norm_fold
    import norm_pkg::*;
#(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] op,
    input  norm_mode_e   mode,
    output logic [W-1:0] scan
);

    logic [W-1:0] diff;

    // Neighbour difference word with a floor at bit 0
    always_comb begin
        diff = (op ^ {op[W-2:0], 1'b0}) | {{(W-1){1'b0}}, 1'b1};
    end

    // Select the word to scan by mode
    always_comb begin
        scan = (mode == NORM_SIGNED) ? diff : op;
    end

endmodule

// File: rtl/norm_lzc.sv
// Module norm_lzc
// Counts the leading zeros of a word.
// Each stage tests the top 16, 8, 4, 2 and then 1 bits (for W=32) of the
// running word for zero. When they are zero, that stage shifts the word
// left by its width and sets its bit of the count. If bit W-1 is still
// clear after the last stage, the word was zero and the count is W.
// Assumes: W is a power of two; combinational.
module norm_lzc
    import norm_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned LG = steps_for(W),
    parameter int unsigned CW = LG + 1
) (
    input  logic [W-1:0]  word,
    output logic [CW-1:0] count
);

    logic [W-1:0]  stage_w [0:LG];
    logic [LG-1:0] partial;

    assign stage_w[0] = word;

    for (genvar s = 0; s < int'(LG); s++) begin : g_step
        localparam int unsigned SH = 1 << (LG - 1 - s);
        logic top_zero;
        // Detect an all-zero upper field of this stage's width
        assign top_zero = (stage_w[s][W-1 -: SH] == '0);
        // Shift past the zero field when found
        assign stage_w[s+1] = top_zero ? (stage_w[s] << SH) : stage_w[s];
        assign partial[LG-1-s] = top_zero;
    end

    // A clear top bit after all stages means the word was zero
    always_comb begin
        if (!stage_w[LG][W-1]) count = CW'(W);
        else                   count = {1'b0, partial};
    end

endmodule

// File: rtl/norm_tzc.sv
// Module norm_tzc
// Counts the zeros below the lowest set bit.
// The operand is ANDed with its two's complement, which keeps only the
// lowest set bit. That one-hot word is encoded to an index with one OR
// tree per index bit. A zero operand gives W.
// Assumes: W is a power of two; combinational.
module norm_tzc
    import norm_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned LG = steps_for(W),
    parameter int unsigned CW = LG + 1
) (
    input  logic [W-1:0]  op,
    output logic [CW-1:0] count
);

    logic [W-1:0]  lowest;
    logic [LG-1:0] index;

    // Keep only the lowest set bit
    always_comb begin
        lowest = op & (~op + W'(1));
    end

    for (genvar k = 0; k < int'(LG); k++) begin : g_enc
        logic [W-1:0] sel;
        for (genvar i = 0; i < int'(W); i++) begin : g_bit
            assign sel[i] = ((i >> k) & 1) != 0;
        end
        // Index bit k is set when the one-hot bit sits at such a position
        assign index[k] = |(lowest & sel);
    end

    // Zero operand has no lowest bit
    always_comb begin
        if (op == '0) count = CW'(W);
        else          count = {1'b0, index};
    end

endmodule

// File: rtl/norm_shift.sv
// Module norm_shift
// Logarithmic left shifter, one stage per bit of the shift amount.
// An amount of W or more clears the word.
// Assumes: combinational.
module norm_shift #(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = 6
) (
    input  logic [W-1:0]  op,
    input  logic [CW-1:0] amt,
    output logic [W-1:0]  res
);

    logic [W-1:0] lvl [0:CW];

    assign lvl[0] = op;

    for (genvar k = 0; k < int'(CW); k++) begin : g_lvl
        if ((1 << k) >= W) begin : g_clear
            // Stage wide enough to empty the word
            assign lvl[k+1] = amt[k] ? '0 : lvl[k];
        end else begin : g_move
            localparam int unsigned SH = 1 << k;
            // Apply this power-of-two step when selected
            assign lvl[k+1] = amt[k] ? (lvl[k] << SH) : lvl[k];
        end
    end

    assign res = lvl[CW];

endmodule

// File: rtl/bit_normalizer.sv
// Module bit_normalizer
// Top of the normalizer.
// Folds the operand by mode, counts the leading zeros of the folded
// word, shifts the original operand by that count, and counts trailing
// zeros in parallel. All results are registered, so the latency is one
// clock. Results load only on a valid operand and hold otherwise.
// Assumes: synchronous active-low reset; inputs stable around the edge.
module bit_normalizer
    import norm_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned LG = steps_for(W),
    parameter int unsigned CW = LG + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_data,
    input  logic          in_signed,
    output logic          out_valid,
    output logic [W-1:0]  out_data,
    output logic [CW-1:0] out_lead,
    output logic [CW-1:0] out_trail
);

    norm_mode_e    mode;
    logic [W-1:0]  scan;
    logic [CW-1:0] lead_c;
    logic [CW-1:0] trail_c;
    logic [W-1:0]  shifted;

    assign mode = norm_mode_e'(in_signed);

    norm_fold #(.W(W)) u_fold (
        .op   (in_data),
        .mode (mode),
        .scan (scan)
    );

    norm_lzc #(.W(W), .LG(LG), .CW(CW)) u_lzc (
        .word  (scan),
        .count (lead_c)
    );

    norm_shift #(.W(W), .CW(CW)) u_shift (
        .op  (in_data),
        .amt (lead_c),
        .res (shifted)
    );

    norm_tzc #(.W(W), .LG(LG), .CW(CW)) u_tzc (
        .op    (in_data),
        .count (trail_c)
    );

    // Result strobe: one cycle behind the operand strobe
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Result registers: load on a valid operand, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data  <= '0;
            out_lead  <= '0;
            out_trail <= '0;
        end else if (in_valid) begin
            out_data  <= shifted;
            out_lead  <= lead_c;
            out_trail <= trail_c;
        end
    end

endmodule

// File: rtl/bit_normalizer_chk.sv
// Module bit_normalizer_chk
// Property checker bound to bit_normalizer.
// Relates registered results to the operand and mode one edge earlier.
module bit_normalizer_chk #(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic [W-1:0]  in_data,
    input logic          in_signed,
    input logic          out_valid,
    input logic [W-1:0]  out_data,
    input logic [CW-1:0] out_lead,
    input logic [CW-1:0] out_trail
);

    assert_valid_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_valid_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_unsigned_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_signed && in_data != '0) |=>
            (out_data[W-1] && out_data == ($past(in_data) << out_lead)));

    assert_unsigned_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_signed && in_data == '0) |=>
            (out_lead == CW'(W) && out_data == '0));

    assert_signed_split_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_signed && in_data != '0 && in_data != '1) |=>
            (out_data[W-1] != out_data[W-2] &&
             out_data == ($past(in_data) << out_lead)));

    assert_signed_flat_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_signed && (in_data == '0 || in_data == '1)) |=>
            (out_lead == CW'(W - 1)));

    assert_trail_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data != '0) |=>
            (out_trail < CW'(W) && (($past(in_data) >> out_trail) & W'(1)) == W'(1)));

    assert_trail_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_data == '0) |=> (out_trail == CW'(W)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_lead) && $stable(out_trail)));

endmodule

bind bit_normalizer bit_normalizer_chk #(.W(W), .CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_signed (in_signed),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_lead  (out_lead),
    .out_trail (out_trail)
);

// File: tb/sim_bit_normalizer.sv
// Directed bench for bit_normalizer: one task per scenario.
module sim_bit_normalizer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        in_signed = 1'b0;
    logic        out_valid;
    logic [31:0] out_data;
    logic [5:0]  out_lead;
    logic [5:0]  out_trail;

    int total = 0;
    int bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    bit_normalizer u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_signed (in_signed),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_lead  (out_lead),
        .out_trail (out_trail)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int ref_lead(input logic [31:0] x, input bit s);
        int n = 0;
        if (s) begin
            for (int i = 30; i >= 0; i--) begin
                if (x[i] == x[31]) n++;
                else break;
            end
        end else begin
            for (int i = 31; i >= 0; i--) begin
                if (!x[i]) n++;
                else break;
            end
        end
        return n;
    endfunction

    function automatic int ref_trail(input logic [31:0] x);
        int n = 0;
        for (int i = 0; i < 32; i++) begin
            if (!x[i]) n++;
            else break;
        end
        return n;
    endfunction

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    // Called on a falling edge: drive one operand, sample one clock later
    task automatic apply(input logic [31:0] x, input bit s, input string req);
        int el = ref_lead(x, s);
        logic [31:0] ed = (el >= 32) ? 32'h0 : (x << el);
        in_data = x; in_signed = s; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid == 1'b1, "R1", {31'b0, out_valid}, 32'h1);
        check(out_lead == 6'(el), req, {26'b0, out_lead}, el);
        check(out_data == ed, req, out_data, ed);
        check(out_trail == 6'(ref_trail(x)), (x == 0) ? "R8" : "R7", {26'b0, out_trail}, ref_trail(x));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(out_valid == 1'b0, "R2", {31'b0, out_valid}, 0);
        check(out_data == 0 && out_lead == 0 && out_trail == 0, "R2", out_data, 0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_unsigned_walk();
        for (int i = 0; i < 32; i++) apply(32'h1 << i, 1'b0, "R3");
        apply(32'hFFFF_FFFF, 1'b0, "R3");
        apply(32'h0001_0000, 1'b0, "R3");
    endtask

    task automatic t_unsigned_zero();
        apply(32'h0, 1'b0, "R4");
    endtask

    task automatic t_unsigned_random();
        for (int i = 0; i < 200; i++) begin
            logic [31:0] r = next_rand();
            apply(r >> next_rand()[4:0], 1'b0, "R3");
        end
    endtask

    task automatic t_signed_corners();
        apply(32'h0, 1'b1, "R6");
        apply(32'hFFFF_FFFF, 1'b1, "R6");
        apply(32'h4000_0000, 1'b1, "R5");
        apply(32'h8000_0000, 1'b1, "R5");
        apply(32'h0000_0001, 1'b1, "R5");
        apply(32'hFFFF_FFFE, 1'b1, "R5");
        apply(32'hFFFF_8000, 1'b1, "R5");
    endtask

    task automatic t_signed_random();
        for (int i = 0; i < 200; i++) begin
            logic [31:0] r = next_rand();
            apply($signed(r) >>> next_rand()[4:0], 1'b1, "R5");
        end
    endtask

    task automatic t_trail_mode();
        logic [5:0] t_u;
        apply(32'h0000_0A00, 1'b0, "R3");
        t_u = out_trail;
        apply(32'h0000_0A00, 1'b1, "R5");
        check(out_trail == t_u, "R9", {26'b0, out_trail}, {26'b0, t_u});
        apply(32'h0, 1'b1, "R6");
        check(out_trail == 6'd32, "R9", {26'b0, out_trail}, 32);
    endtask

    task automatic t_hold();
        apply(32'h0003_0000, 1'b0, "R3");
        in_data = 32'h0000_0001; in_signed = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", {31'b0, out_valid}, 0);
        check(out_data == 32'hC000_0000, "R10", out_data, 32'hC000_0000);
        check(out_lead == 6'd14 && out_trail == 6'd16, "R10", {20'b0, out_lead, out_trail}, {20'b0, 6'd14, 6'd16});
    endtask

    task automatic t_back_to_back();
        in_data = 32'h0000_00F0; in_signed = 1'b0; in_valid = 1'b1;
        @(negedge clk);
        check(out_valid && out_lead == 6'd24, "R1", {26'b0, out_lead}, 24);
        in_data = 32'hFFFF_FF00; in_signed = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(out_valid && out_lead == 6'd23 && out_data == 32'h8000_0000, "R5", out_data, 32'h8000_0000);
        @(negedge clk);
        check(!out_valid, "R1", {31'b0, out_valid}, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_unsigned_walk();
        t_unsigned_zero();
        t_unsigned_random();
        t_signed_corners();
        t_signed_random();
        t_trail_mode();
        t_hold();
        t_back_to_back();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule